// File: doc/BRIEF.md
# Single-Channel Burst Copy Engine

This block is the sequencer of one DMA channel. Given a source byte address, a destination byte address and a byte count, it copies the buffer over a 32-bit bus. It works in bursts. Each burst is read word by word into a small local store and then written out word by word. Each burst carries at most a parameter-sized number of bytes. The final burst carries whatever is left. Every burst phase must win a shared bus port through a request/grant handshake before it issues any beat.

The channel reports its progress as a 4-bit status code and raises an interrupt when it reaches a final state. It stops on the first bus error and records whether that error came from a read or from a write. A soft reset returns it to idle. If a bus beat is outstanding when the soft reset arrives, the channel first lets that beat finish. Register decoding and arbitration between channels belong to the surrounding logic.

Top module: `dma_chan_engine`

## Requirements
- R1: After `rst_n` is held low for a clock edge, status is 2 (idle), `irq` is 0 and `bus_req` and `bus_valid` are 0.
- R2: No beat is issued until `bus_gnt` has been seen high in the request state. The grant is taken as held until the beat flagged by `bus_last` completes, and `bus_last` marks the final beat of every burst phase.
- R3: A copy of L bytes proceeds as alternating read and write phases. Each pair of phases moves min(remaining, MAX_BURST_BYTES) bytes, so every burst is full-size except possibly the last. All reads of a burst complete before its first write.
- R4: Beat addresses are word aligned. Read beats visit the source addresses in ascending order and write beats visit the destination addresses in ascending order. Each address advances by 4 per beat and continues across bursts, and each destination word receives the matching source word unchanged.
- R5: When the last write completes, status becomes 0 (success). In any final state (codes 0, 1 and 3), `irq` is 1 whenever `irq_off` is 0.
- R6: While `irq_off` is 1, `irq` stays 0. The input acts live, so clearing it in a final state raises `irq`.
- R7: A beat completing with `bus_err` during a read phase ends the copy with status 1. No further beats are issued, and the words of that burst are not written.
- R8: A beat completing with `bus_err` during a write phase ends the copy with status 3, and no further beats are issued.
- R9: A soft reset in any state other than a data phase returns the channel to status 2 on the next edge. During a data phase, the outstanding beat keeps `bus_valid` high with a stable address until `bus_ready`, and the channel then goes to status 2 with no further beat. `irq` is 0 afterwards.
- R10: A start with a length of zero moves to status 0 on the next edge without issuing any beat.
- R11: A final status (0, 1 or 3) and its `irq` hold until a soft reset. A start applied in a final state is ignored and causes no bus activity.
- R12: Busy states report codes above 3: 4 (waiting for read grant), 5 (reading), 6 (waiting for write grant), 7 (writing). `bus_req` is high only in these states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle command to begin a copy (honoured only when idle) |
| src_addr | input | ADDR_W | Source byte address, word aligned |
| dst_addr | input | ADDR_W | Destination byte address, word aligned |
| xfer_len | input | LEN_W | Byte count, multiple of 4 |
| soft_reset | input | 1 | Return to idle, after any outstanding beat |
| irq_off | input | 1 | Suppresses the interrupt output |
| status | output | 4 | Channel status code |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Request for the shared bus port |
| bus_gnt | input | 1 | Grant of the shared bus port |
| bus_valid | output | 1 | Beat presented |
| bus_we | output | 1 | Beat is a write (1) or a read (0) |
| bus_last | output | 1 | Beat is the final one of the burst phase |
| bus_addr | output | ADDR_W | Beat byte address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Beat accepted this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_err | input | 1 | Beat failed, valid with bus_ready |

## Verification
The bench aims at lengths that are not a multiple of the burst size. An engine that rounds the last burst wrongly would copy too many or too few words, or log burst sizes that differ from the expected pattern. It injects an error in the middle of a second read burst and in the middle of a write burst. A design that mixed up the two error codes, or kept writing a burst it failed to read, would show the wrong status or the wrong count of written words. It stalls a beat and applies a soft reset during the stall. A design that dropped the beat or kept running would show a change in the beat while it was pending or an extra beat afterwards. It also checks that a zero-length start finishes at once and that a start in a final state leaves the bus idle.

// File: rtl/dma_chan_pkg.sv
// Package: shared encodings for the burst copy engine.
// The state encoding equals the status code seen at the port, so the status
// output is the state register itself.
package dma_chan_pkg;

    typedef enum logic [3:0] {
        ST_OK      = 4'd0,
        ST_RD_FAIL = 4'd1,
        ST_IDLE    = 4'd2,
        ST_WR_FAIL = 4'd3,
        ST_RD_REQ  = 4'd4,
        ST_RD_XFER = 4'd5,
        ST_WR_REQ  = 4'd6,
        ST_WR_XFER = 4'd7
    } chan_state_e;

    localparam int WORD_BYTES = 4;
    localparam int DATA_W     = 32;

endpackage

// File: rtl/dma_burst_sizer.sv
// Module: dma_burst_sizer
// Picks the size of the next burst from the bytes still to move.
// Assumes rem_bytes and MAX_BURST_BYTES are multiples of 4 and that
// LEN_W can hold MAX_BURST_BYTES. Purely combinational.
module dma_burst_sizer #(
    parameter int LEN_W           = 16,
    parameter int MAX_BURST_BYTES = 16
) (
    input  logic [LEN_W-1:0] rem_bytes,
    output logic [LEN_W-1:0] burst_bytes,
    output logic             final_burst
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_BURST_BYTES);

    // Clamp the remaining count to the burst cap and flag the final burst.
    always_comb begin
        if (rem_bytes > CAP) begin
            burst_bytes = CAP;
            final_burst = 1'b0;
        end else begin
            burst_bytes = rem_bytes;
            final_burst = 1'b1;
        end
    end
endmodule

// File: rtl/dma_burst_buf.sv
// Module: dma_burst_buf
// Holds one burst of read data until it is written out.
// One write port, one asynchronous read port. The contents need no reset,
// because every word is written by a read beat before it is sent.
module dma_burst_buf #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] store_q [WORDS];

    // Capture a read beat's data into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) store_q[wr_idx] <= wr_data;
    end

    assign rd_data = store_q[rd_idx];
endmodule

// File: rtl/dma_chan_engine.sv
// Module: dma_chan_engine (top)
// One DMA channel: copies xfer_len bytes from src_addr to dst_addr in bursts
// of up to MAX_BURST_BYTES. Each burst is read into a local store and then
// written out. Each phase requests the shared bus and waits for a grant. The
// grant is taken as held until the beat flagged bus_last completes.
// A beat completes on bus_valid && bus_ready, with bus_rdata and bus_err
// sampled in that cycle. Addresses and length are assumed word aligned;
// the low two length bits are ignored.
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int LEN_W           = 16,
    parameter int MAX_BURST_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              soft_reset,
    input  logic              irq_off,
    output logic [3:0]        status,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic              bus_we,
    output logic              bus_last,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ready,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_err
);
    localparam int BURST_WORDS = MAX_BURST_BYTES / WORD_BYTES;
    localparam int IDX_W       = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;

    chan_state_e       state_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [LEN_W-1:0]  rem_q;
    logic [IDX_W-1:0]  idx_q;
    logic              stop_q;

    logic [LEN_W-1:0]  burst_bytes;
    logic              final_burst;
    logic [LEN_W-1:0]  words_m1;
    logic              last_beat;
    logic              beat_done;
    logic              in_xfer;
    logic              stop_now;
    logic [LEN_W-1:0]  len_aligned;
    logic [ADDR_W-1:0] beat_base;

    dma_burst_sizer #(
        .LEN_W          (LEN_W),
        .MAX_BURST_BYTES(MAX_BURST_BYTES)
    ) u_sizer (
        .rem_bytes  (rem_q),
        .burst_bytes(burst_bytes),
        .final_burst(final_burst)
    );

    dma_burst_buf #(
        .WORDS (BURST_WORDS),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_buf (
        .clk    (clk),
        .wr_en  (state_q == ST_RD_XFER && beat_done && !bus_err),
        .wr_idx (idx_q),
        .wr_data(bus_rdata),
        .rd_idx (idx_q),
        .rd_data(bus_wdata)
    );

    // Decode beat position, completion and the pending-stop condition.
    always_comb begin
        words_m1    = (burst_bytes >> 2) - LEN_W'(1);
        last_beat   = (LEN_W'(idx_q) == words_m1);
        in_xfer     = (state_q == ST_RD_XFER) || (state_q == ST_WR_XFER);
        beat_done   = in_xfer && bus_ready;
        stop_now    = stop_q || soft_reset;
        len_aligned = {xfer_len[LEN_W-1:2], 2'b00};
        beat_base   = (state_q == ST_WR_XFER) ? dst_q : src_q;
    end

    // Drive the bus side and the status outputs from the state register.
    always_comb begin
        bus_req   = (state_q == ST_RD_REQ) || (state_q == ST_RD_XFER) ||
                    (state_q == ST_WR_REQ) || (state_q == ST_WR_XFER);
        bus_valid = in_xfer;
        bus_we    = (state_q == ST_WR_XFER);
        bus_last  = in_xfer && last_beat;
        bus_addr  = beat_base + ADDR_W'({idx_q, 2'b00});
        status    = state_q;
        irq       = ((state_q == ST_OK) || (state_q == ST_RD_FAIL) ||
                     (state_q == ST_WR_FAIL)) && !irq_off;
    end

    // Channel sequencer: phases, pointer advance, errors and soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= '0;
            dst_q   <= '0;
            rem_q   <= '0;
            idx_q   <= '0;
            stop_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start && !soft_reset) begin
                        src_q   <= src_addr;
                        dst_q   <= dst_addr;
                        rem_q   <= len_aligned;
                        idx_q   <= '0;
                        state_q <= (len_aligned == '0) ? ST_OK : ST_RD_REQ;
                    end
                end
                ST_RD_REQ: begin
                    if (soft_reset)   state_q <= ST_IDLE;
                    else if (bus_gnt) state_q <= ST_RD_XFER;
                end
                ST_RD_XFER: begin
                    if (soft_reset) stop_q <= 1'b1;
                    if (beat_done) begin
                        if (stop_now) begin
                            stop_q  <= 1'b0;
                            idx_q   <= '0;
                            state_q <= ST_IDLE;
                        end else if (bus_err) begin
                            state_q <= ST_RD_FAIL;
                        end else if (last_beat) begin
                            idx_q   <= '0;
                            state_q <= ST_WR_REQ;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                ST_WR_REQ: begin
                    if (soft_reset)   state_q <= ST_IDLE;
                    else if (bus_gnt) state_q <= ST_WR_XFER;
                end
                ST_WR_XFER: begin
                    if (soft_reset) stop_q <= 1'b1;
                    if (beat_done) begin
                        if (stop_now) begin
                            stop_q  <= 1'b0;
                            idx_q   <= '0;
                            state_q <= ST_IDLE;
                        end else if (bus_err) begin
                            state_q <= ST_WR_FAIL;
                        end else if (last_beat) begin
                            idx_q   <= '0;
                            src_q   <= src_q + ADDR_W'(burst_bytes);
                            dst_q   <= dst_q + ADDR_W'(burst_bytes);
                            rem_q   <= rem_q - burst_bytes;
                            state_q <= final_burst ? ST_OK : ST_RD_REQ;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                default: begin
                    if (soft_reset) state_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_engine_chk.sv
// Module: dma_chan_engine_chk
// Port-level temporal checks for dma_chan_engine, attached by bind.
module dma_chan_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_reset,
    input logic              irq_off,
    input logic [3:0]        status,
    input logic              irq,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready
);
    logic fin;
    assign fin = (status == 4'd0) || (status == 4'd1) || (status == 4'd3);

    // R9: an unaccepted beat stays presented and unchanged
    p_beat_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we));

    // R2: the first beat of a phase follows a grant
    p_beat_after_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> $past(bus_gnt));

    // R5: irq only in a final state with irq_off low
    p_irq_final_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fin && !irq_off);

    // R11: final status holds until a soft reset
    p_final_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fin && !soft_reset |=> status == $past(status));

    // R9: soft reset with no beat outstanding goes idle next edge
    p_soft_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset && !bus_valid |=> status == 4'd2 && !irq);

    // R4: beat addresses are word aligned
    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> bus_addr[1:0] == 2'b00);

    // R12: no bus request outside the busy codes
    p_req_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> status > 4'd3);
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_reset(soft_reset),
    .irq_off   (irq_off),
    .status    (status),
    .irq       (irq),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_ready (bus_ready)
);

// File: tb/tb_dma_chan_engine.sv
`timescale 1ns/1ps
module tb_dma_chan_engine;
    localparam int MAXB = 16;
    localparam int MW   = MAXB / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_addr = '0, dst_addr = '0;
    logic [15:0] xfer_len = '0;
    logic        soft_reset = 1'b0, irq_off = 1'b0;
    logic [3:0]  status;
    logic        irq, bus_req, bus_valid, bus_we, bus_last;
    logic        bus_gnt = 1'b0, bus_ready = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;

    dma_chan_engine #(.ADDR_W(32), .LEN_W(16), .MAX_BURST_BYTES(MAXB)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
        .dst_addr(dst_addr), .xfer_len(xfer_len), .soft_reset(soft_reset),
        .irq_off(irq_off), .status(status), .irq(irq), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_last(bus_last), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_err(bus_err));

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    logic [31:0] mem [0:511];
    logic [31:0] expw [0:63];
    int  runs [0:63];
    int  nruns = 0, run_len = 0;
    bit  run_we = 1'b0;
    int  beat_cnt = 0, write_cnt = 0, grant_viol = 0, order_viol = 0;
    int  exp_rd_word = 0, exp_wr_word = 0;
    int  seen = 0;
    bit  stall = 1'b0, err_rd = 1'b0, err_wr = 1'b0;
    logic [31:0] err_addr = '0;
    int  gdelay = 0, gcnt = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bus port model: grant after a random delay, random ready, memory, logging.
    initial begin
        forever begin
            @(negedge clk);
            bus_ready = 1'b0;
            bus_err   = 1'b0;
            seen = seen | (1 << status);
            if (!bus_req) begin
                bus_gnt = 1'b0;
                gcnt = 0;
            end else if (!bus_gnt) begin
                if (gcnt >= gdelay) bus_gnt = 1'b1;
                else gcnt++;
            end
            if (bus_valid && !bus_gnt) grant_viol++;
            if (bus_valid && bus_gnt && !stall && ($urandom % 3 != 0)) begin
                bus_ready = 1'b1;
                beat_cnt++;
                if (bus_we) begin
                    if (bus_addr != exp_wr_word * 4) order_viol++;
                    exp_wr_word++;
                    if (err_wr && bus_addr == err_addr) bus_err = 1'b1;
                    else begin
                        mem[bus_addr[10:2]] = bus_wdata;
                        write_cnt++;
                    end
                end else begin
                    if (bus_addr != exp_rd_word * 4) order_viol++;
                    exp_rd_word++;
                    bus_rdata = mem[bus_addr[10:2]];
                    if (err_rd && bus_addr == err_addr) bus_err = 1'b1;
                end
                if (run_len == 0 || bus_we != run_we) begin
                    if (run_len > 0 && nruns < 64) begin runs[nruns] = run_len; nruns++; end
                    run_we = bus_we;
                    run_len = 1;
                end else run_len++;
                if (bus_last) begin
                    bus_gnt = 1'b0;
                    gcnt = 0;
                    gdelay = $urandom % 4;
                end
            end
        end
    end

    task automatic clear_log(input int src, input int dst);
        nruns = 0; run_len = 0; beat_cnt = 0; write_cnt = 0;
        grant_viol = 0; order_viol = 0; seen = 0;
        exp_rd_word = src / 4; exp_wr_word = dst / 4;
    endtask

    task automatic pulse_start(input int src, input int dst, input int len);
        @(negedge clk);
        src_addr = src; dst_addr = dst; xfer_len = 16'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_reset = 1'b1;
        @(negedge clk);
        soft_reset = 1'b0;
    endtask

    task automatic fill(input int src, input int dst, input int len);
        for (int i = 0; i < len / 4; i++) begin
            expw[i] = $urandom;
            mem[src / 4 + i] = expw[i];
            mem[dst / 4 + i] = 32'hDEAD_0000 + i;
        end
        mem[dst / 4 + len / 4] = 32'hF00D_F00D;
    endtask

    task automatic wait_final(input string req);
        int n = 0;
        while (!((status <= 4'd3) && (status != 4'd2)) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 5000, {req, " finishes"}, n, 0);
    endtask

    // Expected burst pattern: alternating read/write runs of min(rem,MAXB)/4.
    task automatic check_runs(input int len, input string req);
        int rem = len;
        int k = 0;
        bit ok = 1'b1;
        if (run_len > 0 && nruns < 64) begin runs[nruns] = run_len; nruns++; run_len = 0; end
        while (rem > 0) begin
            int w = (rem > MAXB ? MAXB : rem) / 4;
            if (k + 1 >= nruns || runs[k] != w || runs[k + 1] != w) ok = 1'b0;
            k += 2;
            rem -= w * 4;
        end
        chk(ok && nruns == k, {req, " burst sizes"}, nruns, k);
    endtask

    task automatic check_copy(input int dst, input int len, input string req);
        int bad = 0;
        for (int i = 0; i < len / 4; i++)
            if (mem[dst / 4 + i] != expw[i]) bad++;
        chk(bad == 0, {req, " copied words"}, bad, 0);
        chk(mem[dst / 4 + len / 4] == 32'hF00D_F00D, {req, " guard word"},
            mem[dst / 4 + len / 4], 32'hF00D_F00D);
    endtask

    task automatic run_copy(input int src, input int dst, input int len, input string req);
        fill(src, dst, len);
        clear_log(src, dst);
        pulse_start(src, dst, len);
        wait_final(req);
        chk(status == 4'd0, {req, " R5 success status"}, status, 0);
        chk(irq == !irq_off, {req, " R5/R6 irq"}, irq, !irq_off);
        check_copy(dst, len, {req, " R4"});
        check_runs(len, {req, " R3"});
        chk(grant_viol == 0, {req, " R2 beat without grant"}, grant_viol, 0);
        chk(order_viol == 0, {req, " R4 address order"}, order_viol, 0);
        pulse_soft();
        chk(status == 4'd2 && irq == 1'b0, {req, " R9 back to idle"}, status, 2);
    endtask

    initial begin
        void'($urandom(32'd2024));
        gdelay = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(status == 4'd2, "R1 idle status", status, 2);
        chk(!irq && !bus_req && !bus_valid, "R1 outputs quiet", {irq, bus_req, bus_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4/R5/R12: directed 40 bytes, short final burst
        run_copy(32'h40, 32'h400, 40, "dir40");
        chk((seen & 32'hF0) == 32'hF0, "R12 busy codes 4..7 seen", seen, 32'hF0);
        chk((seen & ~32'hFF) == 0, "R12 no code above 7", seen, 0);

        // R3: exact multiple and single short burst
        run_copy(32'h80, 32'h480, 32, "dir32");
        run_copy(32'hC0, 32'h500, 4, "dir4");

        // R6: irq suppressed, then released live
        irq_off = 1'b1;
        run_copy(32'h10, 32'h600, 24, "R6");
        fill(32'h10, 32'h600, 8);
        clear_log(32'h10, 32'h600);
        pulse_start(32'h10, 32'h600, 8);
        wait_final("R6b");
        chk(irq == 1'b0, "R6 irq held low", irq, 0);
        @(negedge clk);
        irq_off = 1'b0;
        @(negedge clk);
        chk(irq == 1'b1, "R6 irq rises when enabled", irq, 1);
        pulse_soft();

        // R10: zero length
        clear_log(0, 0);
        pulse_start(32'h20, 32'h700, 0);
        chk(status == 4'd0 && irq, "R10 zero length success", status, 0);
        chk(beat_cnt == 0, "R10 no beats", beat_cnt, 0);

        // R11: start ignored in a final state
        pulse_start(32'h20, 32'h700, 64);
        repeat (10) @(negedge clk);
        chk(status == 4'd0, "R11 final status held", status, 0);
        chk(beat_cnt == 0 && !bus_req, "R11 no bus activity", beat_cnt, 0);
        pulse_soft();
        chk(status == 4'd2 && !irq, "R9 soft reset clears irq", status, 2);

        // R7: read error in the second burst
        fill(32'h100, 32'h800, 48);
        clear_log(32'h100, 32'h800);
        err_rd = 1'b1; err_addr = 32'h100 + 20;
        pulse_start(32'h100, 32'h800, 48);
        wait_final("R7");
        chk(status == 4'd1, "R7 read error status", status, 1);
        chk(irq == 1'b1, "R7 irq on error", irq, 1);
        chk(write_cnt == MW, "R7 failed burst not written", write_cnt, MW);
        repeat (5) @(negedge clk);
        chk(!bus_valid && beat_cnt == MW * 2 + 2, "R7 no further beats", beat_cnt, MW * 2 + 2);
        err_rd = 1'b0;
        pulse_soft();

        // R8: write error on third write
        fill(32'h140, 32'h900, 32);
        clear_log(32'h140, 32'h900);
        err_wr = 1'b1; err_addr = 32'h900 + 8;
        pulse_start(32'h140, 32'h900, 32);
        wait_final("R8");
        chk(status == 4'd3, "R8 write error status", status, 3);
        chk(write_cnt == 2, "R8 writes before error", write_cnt, 2);
        repeat (5) @(negedge clk);
        chk(beat_cnt == MW + 3, "R8 no further beats", beat_cnt, MW + 3);
        err_wr = 1'b0;
        pulse_soft();

        // R9: soft reset while a read beat is stalled
        fill(32'h180, 32'hA00, 32);
        clear_log(32'h180, 32'hA00);
        stall = 1'b1;
        pulse_start(32'h180, 32'hA00, 32);
        begin
            int n = 0;
            while (!bus_valid && n < 50) begin @(negedge clk); n++; end
        end
        soft_reset = 1'b1;
        @(negedge clk);
        soft_reset = 1'b0;
        chk(status == 4'd5 && bus_valid, "R9 beat kept pending", status, 5);
        repeat (3) @(negedge clk);
        chk(bus_valid && bus_addr == 32'h180, "R9 beat stable", bus_addr, 32'h180);
        stall = 1'b0;
        begin
            int n = 0;
            while (status != 4'd2 && n < 50) begin @(negedge clk); n++; end
        end
        repeat (3) @(negedge clk);
        chk(status == 4'd2 && !bus_req, "R9 idle after beat", status, 2);
        chk(beat_cnt == 1 && write_cnt == 0, "R9 only outstanding beat done", beat_cnt, 1);

        // Random copies: R3, R4, R5
        for (int t = 0; t < 10; t++) begin
            int len = (1 + $urandom % 24) * 4;
            int src = ($urandom % 64) * 4;
            int dst = 32'h400 + ($urandom % 64) * 4;
            run_copy(src, dst, len, "rand R3");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule